// File: doc/BRIEF.md
# Bus-Master DMA Channel Controller

This block is one DMA channel of a storage host adapter. Software loads a byte count, a memory address and a descriptor-list address into start registers, then issues a start command. The start values are copied into working registers, and the channel begins to serve burst requests from the device-side data port. Each accepted burst becomes a single request on a simple memory port. The request uses the working address and a length clipped to the bytes still owed. The working count then shrinks and the working address advances by the same amount.

The status register records completion, abort and direction faults, and it mirrors the interrupt line of the SCSI core. How status is cleared depends on a mode bit in a separate bus-control register. In one mode, software writes ones to clear bits. In the other mode, reading the status register clears it. The burst-flush command and descriptor-list walking are accepted as commands but have no effect on data movement.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After synchronous reset, the registers read as follows: command (index 0) 0, working count (index 3) 0, working address (index 4) 0xFFFFFFFF, working descriptor address (index 7) 0xFFFFFFFD and status (index 5) 0. `irq_out` and `mem_valid` are low.
- R2: The start count (index 1), start address (index 2) and start descriptor address (index 6) read back the values written to them. The command register (index 0) reads back the low 8 bits written. Writes to indices 3, 4 and 7 leave those registers unchanged.
- R3: A command write whose bits [1:0] are 3 (start) copies index 1 into index 3, index 2 into index 4 and index 6 into index 7. It also clears status bits [5:0] and enables the channel.
- R4: While the channel is enabled, a burst request whose direction matches command bit 7 (1 = device to memory) is accepted. One cycle later `mem_valid` pulses with `mem_addr` equal to the working address, `mem_len` equal to the smaller of the requested length and the working count, and `mem_write` equal to command bit 7. In that same update the working count drops by the clipped length and the working address grows by it.
- R5: When an accepted burst leaves the working count at zero, status bit 3 (done) is set. Later bursts move no data.
- R6: While the channel is enabled, a burst request whose direction differs from command bit 7 produces no memory request and changes neither working register. It sets status bit 1 (error).
- R7: A command with bits [1:0] = 0 (idle) disables the channel. A command with bits [1:0] = 2 (abort) disables the channel and sets status bit 2. While the channel is disabled, bursts are dropped without setting error. A command with bits [1:0] = 1 (flush) leaves the channel state unchanged.
- R8: The bus-control register is at index 8 and reads back what was written. When its bit 24 is 1, a write to status clears each of bits 1, 2 and 3 that is written as 1. In this mode, reads do not clear status.
- R9: When bus-control bit 24 is 0, writes to status are ignored. A status read returns the current bits and then clears bits 1, 2 and 3.
- R10: Status bit 4 reads as 1 whenever `scsi_irq_in` is high.
- R11: A `scsi_cmd_done` pulse forces the working count to 0 and sets done.
- R12: `irq_out` is high when done is set and command bit 6 is 1, or when `scsi_irq_in` is high.
- R13: If an event sets a status bit in the same cycle that a read or a write would clear that bit, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives read side effects) |
| reg_idx | input | 4 | Register word index (0-7 channel, 8 bus-control) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx`, combinational |
| brq_valid | input | 1 | Burst request from the device-side data port |
| brq_dir | input | 1 | Burst direction, 1 = device to memory |
| brq_len | input | 16 | Requested burst length in bytes |
| mem_valid | output | 1 | One-cycle memory request pulse |
| mem_write | output | 1 | Memory request is a write (device to memory) |
| mem_addr | output | 32 | Memory request byte address |
| mem_len | output | 16 | Memory request length in bytes |
| scsi_irq_in | input | 1 | Interrupt level from the SCSI core |
| scsi_cmd_done | input | 1 | Pulse: SCSI command completed |
| irq_out | output | 1 | Channel interrupt |

## Verification
The risky overlap is a burst that drains the count, and so sets done, in the same cycle that software clears status. The clear can come from a status read in read-to-clear mode or from a write of ones in write-to-clear mode. The bench drives the finishing burst and the status access in one cycle, in both modes. It then expects the sampled read value to lack done and the following read to show it. Seeded random runs mix clipped bursts and wrong-direction bursts with status reads, so error sets and read clears also meet.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    localparam int unsigned REG_W = 32;
    localparam int unsigned IDX_W = 4;

    // register word indices
    localparam logic [IDX_W-1:0] RI_CMD    = 4'd0;
    localparam logic [IDX_W-1:0] RI_SCNT   = 4'd1;
    localparam logic [IDX_W-1:0] RI_SADR   = 4'd2;
    localparam logic [IDX_W-1:0] RI_WCNT   = 4'd3;
    localparam logic [IDX_W-1:0] RI_WADR   = 4'd4;
    localparam logic [IDX_W-1:0] RI_STAT   = 4'd5;
    localparam logic [IDX_W-1:0] RI_SDESC  = 4'd6;
    localparam logic [IDX_W-1:0] RI_WDESC  = 4'd7;
    localparam logic [IDX_W-1:0] RI_BUSCTL = 4'd8;

    // command bits
    localparam int unsigned CMD_DIR_BIT  = 7;
    localparam int unsigned CMD_DONE_IE  = 6;

    // status bits
    localparam int unsigned ST_W        = 6;
    localparam int unsigned ST_FAULT    = 1;
    localparam int unsigned ST_HALTED   = 2;
    localparam int unsigned ST_FINISH   = 3;
    localparam int unsigned ST_CORE_IRQ = 4;

    localparam int unsigned CTL_W2C_BIT = 24;

    localparam logic [REG_W-1:0] WADR_RST  = 32'hFFFF_FFFF;
    localparam logic [REG_W-1:0] WDESC_RST = 32'hFFFF_FFFD;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_FLUSH = 2'd1,
        OP_ABORT = 2'd2,
        OP_START = 2'd3
    } dma_op_e;

    typedef struct packed {
        logic             take;     // burst accepted
        logic             bad_dir;  // direction mismatch while enabled
        logic             last;     // count reaches zero after this burst
        logic [REG_W-1:0] len;      // clipped length
    } burst_res_t;

    function automatic logic [REG_W-1:0] clip_len(input logic [REG_W-1:0] want,
                                                   input logic [REG_W-1:0] left);
        return (want < left) ? want : left;
    endfunction

endpackage

// File: rtl/dma_burst_gate.sv
module dma_burst_gate
    import dma_chan_pkg::*;
#(
    parameter int unsigned LEN_W = 16
) (
    input  logic             running,
    input  logic             want_dir,
    input  logic [REG_W-1:0] wcnt,
    input  logic             req_valid,
    input  logic             req_dir,
    input  logic [LEN_W-1:0] req_len,
    output burst_res_t       res
);
    logic [REG_W-1:0] len_ext;
    logic             dir_ok;

    always_comb begin
        len_ext     = REG_W'(req_len);
        dir_ok      = (req_dir == want_dir);
        res.len     = clip_len(len_ext, wcnt);
        res.take    = req_valid && running && dir_ok;
        res.bad_dir = req_valid && running && !dir_ok;
        res.last    = (wcnt == res.len);
    end
endmodule

// File: rtl/dma_status_bits.sv
module dma_status_bits
    import dma_chan_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clr_all,
    input  logic [ST_W-1:0] clr_mask,
    input  logic [ST_W-1:0] set_mask,
    output logic [ST_W-1:0] stat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else begin
            stat <= (stat & ~(clr_all ? {ST_W{1'b1}} : {ST_W{1'b0}}) & ~clr_mask) | set_mask;
        end
    end

    // R13
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (set_mask != '0) |=> ((stat & $past(set_mask)) == $past(set_mask)));
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
    import dma_chan_pkg::*;
#(
    parameter int unsigned LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [3:0]       reg_idx,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             brq_valid,
    input  logic             brq_dir,
    input  logic [LEN_W-1:0] brq_len,
    output logic             mem_valid,
    output logic             mem_write,
    output logic [31:0]      mem_addr,
    output logic [LEN_W-1:0] mem_len,
    input  logic             scsi_irq_in,
    input  logic             scsi_cmd_done,
    output logic             irq_out
);
    logic [7:0]       cmd;
    logic [REG_W-1:0] scnt, sadr, sdesc;
    logic [REG_W-1:0] wcnt, wadr, wdesc;
    logic [REG_W-1:0] busctl;
    logic             running;
    logic [ST_W-1:0]  stat;

    burst_res_t       bres;
    logic             wr_cmd;
    dma_op_e          op;
    logic             w2c_mode;
    logic [ST_W-1:0]  clr_mask, set_mask;
    logic             start_clr;

    dma_burst_gate #(.LEN_W(LEN_W)) u_gate (
        .running   (running),
        .want_dir  (cmd[CMD_DIR_BIT]),
        .wcnt      (wcnt),
        .req_valid (brq_valid),
        .req_dir   (brq_dir),
        .req_len   (brq_len),
        .res       (bres)
    );

    always_comb begin
        wr_cmd    = reg_wr && (reg_idx == RI_CMD);
        op        = dma_op_e'(reg_wdata[1:0]);
        w2c_mode  = busctl[CTL_W2C_BIT];
        start_clr = wr_cmd && (op == OP_START);

        clr_mask = '0;
        if (reg_wr && (reg_idx == RI_STAT) && w2c_mode)
            clr_mask[ST_FINISH:ST_FAULT] = reg_wdata[ST_FINISH:ST_FAULT];
        if (reg_rd && (reg_idx == RI_STAT) && !w2c_mode)
            clr_mask[ST_FINISH:ST_FAULT] = '1;

        set_mask             = '0;
        set_mask[ST_FAULT]   = bres.bad_dir;
        set_mask[ST_HALTED]  = wr_cmd && (op == OP_ABORT);
        set_mask[ST_FINISH]  = (bres.take && bres.last) || scsi_cmd_done;
    end

    dma_status_bits u_stat (
        .clk      (clk),
        .rst      (rst),
        .clr_all  (start_clr),
        .clr_mask (clr_mask),
        .set_mask (set_mask),
        .stat     (stat)
    );

    always_comb begin
        case (reg_idx)
            RI_CMD:    reg_rdata = {24'd0, cmd};
            RI_SCNT:   reg_rdata = scnt;
            RI_SADR:   reg_rdata = sadr;
            RI_WCNT:   reg_rdata = wcnt;
            RI_WADR:   reg_rdata = wadr;
            RI_STAT:   reg_rdata = {{(REG_W-ST_W){1'b0}}, stat[5],
                                    stat[ST_CORE_IRQ] | scsi_irq_in, stat[3:0]};
            RI_SDESC:  reg_rdata = sdesc;
            RI_WDESC:  reg_rdata = wdesc;
            RI_BUSCTL: reg_rdata = busctl;
            default:   reg_rdata = '0;
        endcase
        irq_out = (stat[ST_FINISH] && cmd[CMD_DONE_IE]) || scsi_irq_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd       <= '0;
            scnt      <= '0;
            sadr      <= '0;
            sdesc     <= '0;
            wcnt      <= '0;
            wadr      <= WADR_RST;
            wdesc     <= WDESC_RST;
            busctl    <= '0;
            running   <= 1'b0;
            mem_valid <= 1'b0;
            mem_write <= 1'b0;
            mem_addr  <= '0;
            mem_len   <= '0;
        end else begin
            mem_valid <= bres.take && (bres.len != '0);
            mem_write <= cmd[CMD_DIR_BIT];
            mem_addr  <= wadr;
            mem_len   <= bres.len[LEN_W-1:0];
            if (bres.take) begin
                wcnt <= wcnt - bres.len;
                wadr <= wadr + bres.len;
            end
            if (reg_wr) begin
                case (reg_idx)
                    RI_CMD: begin
                        cmd <= reg_wdata[7:0];
                        case (op)
                            OP_START: begin
                                wcnt    <= scnt;
                                wadr    <= sadr;
                                wdesc   <= sdesc;
                                running <= 1'b1;
                            end
                            OP_IDLE, OP_ABORT: running <= 1'b0;
                            default: ;
                        endcase
                    end
                    RI_SCNT:   scnt   <= reg_wdata;
                    RI_SADR:   sadr   <= reg_wdata;
                    RI_SDESC:  sdesc  <= reg_wdata;
                    RI_BUSCTL: busctl <= reg_wdata;
                    default: ;
                endcase
            end
            if (scsi_cmd_done) wcnt <= '0;
        end
    end

    // R3
    start_load_chk: assert property (@(posedge clk) disable iff (rst)
        (start_clr && !scsi_cmd_done) |=> (wcnt == $past(scnt)));

    // R4
    addr_track_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !$past(reg_wr)) |-> (wadr == mem_addr + REG_W'(mem_len)));

    // R5
    zero_done_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && wcnt == '0) |-> stat[ST_FINISH]);

    // R6
    bad_dir_err_chk: assert property (@(posedge clk) disable iff (rst)
        bres.bad_dir |=> (stat[ST_FAULT] && !mem_valid));

    // R11
    cmd_done_chk: assert property (@(posedge clk) disable iff (rst)
        scsi_cmd_done |=> (wcnt == '0 && stat[ST_FINISH]));

    // R12
    core_irq_chk: assert property (@(posedge clk) disable iff (rst)
        scsi_irq_in |-> irq_out);
endmodule

// File: tb/dma_chan_ctrl_bench.sv
`timescale 1ns/100ps
module dma_chan_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 0, reg_rd = 0;
    logic [3:0]  reg_idx = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        brq_valid = 0, brq_dir = 0;
    logic [15:0] brq_len = 0;
    logic        mem_valid, mem_write;
    logic [31:0] mem_addr;
    logic [15:0] mem_len;
    logic        scsi_irq_in = 0, scsi_cmd_done = 0;
    logic        irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dma_chan_ctrl u_dma_chan_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .brq_valid(brq_valid),
        .brq_dir(brq_dir), .brq_len(brq_len), .mem_valid(mem_valid),
        .mem_write(mem_write), .mem_addr(mem_addr), .mem_len(mem_len),
        .scsi_irq_in(scsi_irq_in), .scsi_cmd_done(scsi_cmd_done), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] clipped(input logic [31:0] want, input logic [31:0] left);
        return (want < left) ? want : left;
    endfunction

    // one cycle with every stimulus; rv samples read data before the edge
    task automatic step(input logic bv, input logic bd, input logic [15:0] bl,
                        input logic rw, input logic rr, input logic [3:0] idx,
                        input logic [31:0] wd, output logic [31:0] rv);
        brq_valid = bv; brq_dir = bd; brq_len = bl;
        reg_wr = rw; reg_rd = rr; reg_idx = idx; reg_wdata = wd;
        #1 rv = reg_rdata;
        @(posedge clk); #1;
        brq_valid = 0; reg_wr = 0; reg_rd = 0; scsi_cmd_done = 0;
    endtask

    task automatic wr(input logic [3:0] idx, input logic [31:0] wd);
        logic [31:0] d;
        step(0, 0, 0, 1, 0, idx, wd, d);
    endtask

    task automatic rd(input logic [3:0] idx, output logic [31:0] rv);
        step(0, 0, 0, 0, 1, idx, 0, rv);
    endtask

    task automatic burst(input logic d, input logic [15:0] l);
        logic [31:0] x;
        step(1, d, l, 0, 0, 0, 0, x);
    endtask

    task automatic rd_chk(input string req, input logic [3:0] idx, input logic [31:0] exp);
        logic [31:0] v;
        rd(idx, v);
        chk(req, v, exp);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset state
        chk("R1 irq_out", {31'd0, irq_out}, 0);
        chk("R1 mem_valid", {31'd0, mem_valid}, 0);
        rd_chk("R1 cmd", 0, 0);
        rd_chk("R1 wcnt", 3, 0);
        rd_chk("R1 wadr", 4, 32'hFFFF_FFFF);
        rd_chk("R1 wdesc", 7, 32'hFFFF_FFFD);
        rd_chk("R1 stat", 5, 0);

        // R2 register access
        wr(1, 32'h100); wr(2, 32'h1000_0000); wr(6, 32'h2000_0040);
        wr(3, 32'hAAAA); wr(4, 32'h5555); wr(7, 32'h1234);
        rd_chk("R2 scnt", 1, 32'h100);
        rd_chk("R2 sadr", 2, 32'h1000_0000);
        rd_chk("R2 sdesc", 6, 32'h2000_0040);
        rd_chk("R2 wcnt ignored", 3, 0);
        rd_chk("R2 wadr ignored", 4, 32'hFFFF_FFFF);
        rd_chk("R2 wdesc ignored", 7, 32'hFFFF_FFFD);

        // R3 start
        wr(0, 32'hFFFF_FF83);
        rd_chk("R2 cmd low byte", 0, 32'h83);
        rd_chk("R3 wcnt load", 3, 32'h100);
        rd_chk("R3 wadr load", 4, 32'h1000_0000);
        rd_chk("R3 wdesc load", 7, 32'h2000_0040);
        rd_chk("R3 stat clear", 5, 0);

        // R4 burst
        burst(1, 16'h40);
        chk("R4 mem_valid", {31'd0, mem_valid}, 1);
        chk("R4 mem_write", {31'd0, mem_write}, 1);
        chk("R4 mem_addr", mem_addr, 32'h1000_0000);
        chk("R4 mem_len", {16'd0, mem_len}, 32'h40);
        rd_chk("R4 wcnt", 3, 32'hC0);
        rd_chk("R4 wadr", 4, 32'h1000_0040);

        // R6 mismatch; R9 read clears
        burst(0, 16'h10);
        chk("R6 no mem", {31'd0, mem_valid}, 0);
        rd_chk("R6 wcnt kept", 3, 32'hC0);
        rd_chk("R6 error bit", 5, 32'h2);
        rd_chk("R9 read cleared", 5, 0);

        // R4 clip, R5 done
        burst(1, 16'h200);
        chk("R4 clip len", {16'd0, mem_len}, 32'hC0);
        chk("R4 clip addr", mem_addr, 32'h1000_0040);
        chk("R12 no ie", {31'd0, irq_out}, 0);
        rd_chk("R5 wcnt zero", 3, 0);
        rd_chk("R4 wadr end", 4, 32'h1000_0100);
        rd_chk("R5 done", 5, 32'h8);
        burst(1, 16'h8);
        chk("R5 no more data", {31'd0, mem_valid}, 0);

        // R8 write-to-clear mode
        wr(8, 32'h0100_0000);
        rd_chk("R8 busctl", 8, 32'h0100_0000);
        wr(1, 32'h10);
        wr(0, 32'hC3);
        burst(1, 16'h10);
        chk("R12 done irq", {31'd0, irq_out}, 1);
        rd_chk("R8 read keeps", 5, 32'h8);
        rd_chk("R8 read keeps again", 5, 32'h8);
        wr(5, 32'h7);
        rd_chk("R8 partial clear", 5, 32'h8);
        wr(5, 32'h8);
        rd_chk("R8 cleared", 5, 0);
        chk("R12 irq low", {31'd0, irq_out}, 0);

        // R3 start clears error
        burst(0, 16'h4);
        rd_chk("R6 error again", 5, 32'h2);
        wr(0, 32'hC3);
        rd_chk("R3 restart clears", 5, 0);

        // R7 abort, flush, idle
        wr(0, 32'h42);
        rd_chk("R7 abort bit", 5, 32'h4);
        burst(0, 16'h4);
        chk("R7 abort drops", {31'd0, mem_valid}, 0);
        rd_chk("R7 no error when off", 5, 32'h4);
        wr(5, 32'h4);
        wr(0, 32'hC3);
        wr(0, 32'hC1);
        burst(1, 16'h4);
        chk("R7 flush keeps running", {31'd0, mem_valid}, 1);
        chk("R7 flush addr", mem_addr, 32'h1000_0000);
        wr(0, 32'h80);
        burst(1, 16'h4);
        chk("R7 idle drops", {31'd0, mem_valid}, 0);
        rd_chk("R7 idle no error", 5, 0);

        // R10 core interrupt mirror
        scsi_irq_in = 1;
        #1 chk("R12 core irq", {31'd0, irq_out}, 1);
        rd_chk("R10 stat bit4", 5, 32'h10);
        scsi_irq_in = 0;
        rd_chk("R10 bit4 gone", 5, 0);

        // R11 command completion
        wr(0, 32'hC3);
        scsi_cmd_done = 1;
        step(0, 0, 0, 0, 0, 0, 0, v);
        rd_chk("R11 wcnt forced", 3, 0);
        rd_chk("R11 done", 5, 32'h8);
        chk("R12 done ie", {31'd0, irq_out}, 1);
        wr(5, 32'h8);

        // R13 collision, write-to-clear mode
        wr(1, 32'h4);
        wr(0, 32'h83);
        step(1, 1, 16'h4, 1, 0, 5, 32'h8, v);
        rd_chk("R13 set beats write clear", 5, 32'h8);
        // R13 collision, read-to-clear mode
        wr(8, 32'h0);
        wr(5, 32'h8);
        rd_chk("R9 write ignored", 5, 32'h8);
        rd_chk("R9 cleared by read", 5, 0);
        wr(0, 32'h83);
        step(1, 1, 16'h4, 0, 1, 5, 0, v);
        chk("R13 read sees old", v, 0);
        rd_chk("R13 set beats read clear", 5, 32'h8);
        rd_chk("R9 then cleared", 5, 0);

        // random mix
        for (int it = 0; it < 150; it++) begin
            logic        w2c, dir;
            logic [31:0] m_cnt, m_adr, cl;
            logic [5:0]  m_st;
            w2c = 1'($urandom % 2);
            dir = 1'($urandom % 2);
            m_cnt = 1 + ($urandom % 400);
            m_adr = $urandom;
            m_st = 0;
            wr(8, {7'd0, w2c, 24'd0});
            wr(1, m_cnt);
            wr(2, m_adr);
            wr(0, {24'd0, dir, 5'd0, 2'd3});
            for (int b = 0; b < 5; b++) begin
                logic        bd;
                logic [15:0] bl;
                bd = (($urandom % 5) == 0) ? ~dir : dir;
                bl = 16'(1 + ($urandom % 128));
                burst(bd, bl);
                if (bd != dir) begin
                    chk("R6 rnd drop", {31'd0, mem_valid}, 0);
                    m_st[1] = 1;
                end else begin
                    cl = clipped({16'd0, bl}, m_cnt);
                    chk("R4 rnd valid", {31'd0, mem_valid}, {31'd0, cl != 0});
                    if (cl != 0) begin
                        chk("R4 rnd addr", mem_addr, m_adr);
                        chk("R4 rnd len", {16'd0, mem_len}, cl);
                    end
                    m_cnt = m_cnt - cl;
                    m_adr = m_adr + cl;
                    if (m_cnt == 0) m_st[3] = 1;
                end
            end
            rd_chk("R4 rnd wcnt", 3, m_cnt);
            rd_chk("R4 rnd wadr", 4, m_adr);
            rd_chk("R5 rnd stat", 5, {26'd0, m_st});
            if (!w2c) m_st[3:1] = 0;
            rd_chk("R9 rnd stat after read", 5, {26'd0, m_st});
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule